// File: doc/BRIEF.md
# ISA Target Cycle Sequencer

This block turns a host transaction that has already been claimed into one target cycle on an ISA-style expansion bus. It drives a 24-bit bus address and an 8-bit data path, and it produces one of four active-low command strobes: IO read, IO write, memory read or memory write. The block runs on the bus clock, so every length below is counted in bus-clock periods.

Each cycle has three phases. The address is set up for one clock, the command strobe is then held for a length that depends on the space and the access width, and the address is held for one more clock after the strobe ends. A request carries the host address, write data, direction, space, width and a flag that tells a BIOS-range access from a default-path one. A default-path memory access above the 16 MB window still runs for its full length, but no memory strobe is asserted. A BIOS-range access always asserts its strobe. Read data and a one-clock done pulse are returned at the end of the cycle.

Top module: `isa_cycle_seq`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both 1 at a rising edge, and `req_valid` is ignored while `req_ready` is 0.
- R2: `isa_addr` carries bits [23:0] of the taken address from the clock after acceptance. It is driven for one clock with no strobe asserted, stays stable through the strobe, and is held one clock after the strobe ends.
- R3: An 8-bit IO access (`req_mem`=0, `req_wide`=0) holds its strobe low for IO8_LEN clocks (default 6).
- R4: A 16-bit IO access (`req_mem`=0, `req_wide`=1) holds its strobe low for IO16_LEN clocks (default 3).
- R5: A memory access holds its strobe low for MEM8_LEN clocks when narrow and MEM16_LEN clocks when wide (defaults 6 and 3).
- R6: The strobe is `ior_n` for an IO read, `iow_n` for an IO write, `memr_n` for a memory read and `memw_n` for a memory write (`req_write`=1 means write). At most one strobe is low at any time.
- R7: A memory access with `req_bios`=0 whose host address has any bit above bit 23 set runs a cycle of the same length with all strobes high, and it still produces done.
- R8: A memory access with `req_bios`=1 asserts its memory strobe whatever the upper address bits are.
- R9: For a read, `rd_data` holds the value `isa_data_in` had during the last clock of the strobe, and it is valid while `done` is 1.
- R10: For a write, `isa_data_oe` is 1 and `isa_data_out` equals the write data on every strobe clock, including a suppressed strobe. `isa_data_oe` is 0 at all other times.
- R11: `done` is 1 for exactly one clock, the clock right after the strobe period. `req_ready` returns to 1 on the next clock.
- R12: While reset is held and just after it, all strobes are high, `done` and `isa_data_oe` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Host address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = IO space |
| req_wide | input | 1 | 1 = 16-bit access timing, 0 = 8-bit |
| req_bios | input | 1 | 1 = BIOS-range access, 0 = default-path access |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 8 | Captured read data |
| isa_addr | output | 24 | Bus address |
| isa_data_out | output | 8 | Bus write data |
| isa_data_oe | output | 1 | Bus data output enable |
| isa_data_in | input | 8 | Bus read data |
| ior_n | output | 1 | IO read strobe, active low |
| iow_n | output | 1 | IO write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |

## Verification
On every cycle the assertions check that at most one strobe is low, that the bus address does not move while the sequencer is busy, that a suppressed high-address cycle keeps the memory strobes high, that the data enable appears only inside a command period, that done never lasts two clocks, and that nothing is driven while idle. Only the bench scenarios can show the exact strobe length for each space and width, which strobe is picked, the clock on which read data is sampled, and that a request raised in the middle of a cycle is dropped. The directed cases cover the 16 MB boundary on both sides and BIOS accesses with high address bits set.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // strobe mask bit order: {io_rd, io_wr, mem_rd, mem_wr}
  typedef logic [3:0] strobe_mask_t;

  function automatic int unsigned pick_len(
    input logic mem, input logic wide,
    input int unsigned io8, input int unsigned io16,
    input int unsigned m8, input int unsigned m16);
    if (mem) return wide ? m16 : m8;
    return wide ? io16 : io8;
  endfunction

  function automatic int unsigned max4(
    input int unsigned a, input int unsigned b,
    input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic strobe_mask_t select_strobe(
    input logic write, input logic mem, input logic mute);
    strobe_mask_t s;
    s = '0;
    if (!mute) begin
      case ({mem, write})
        2'b00:   s = 4'b1000;
        2'b01:   s = 4'b0100;
        2'b10:   s = 4'b0010;
        default: s = 4'b0001;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/isa_seq_timer.sv
module isa_seq_timer #(
  parameter int unsigned MAX_LEN = 6,
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             last_beat
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CNT_W'(1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last_beat = run && (cnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(MAX_LEN)) else $error("count out of range"); // R5
endmodule

// File: rtl/isa_seq_strobe.sv
module isa_seq_strobe
  import isa_seq_pkg::*;
(
  input  logic active,
  input  logic write,
  input  logic mem,
  input  logic mute,
  output logic ior_n,
  output logic iow_n,
  output logic memr_n,
  output logic memw_n
);
  strobe_mask_t sel;

  always_comb begin
    sel = active ? select_strobe(write, mem, mute) : '0;
  end

  assign ior_n  = ~sel[3];
  assign iow_n  = ~sel[2];
  assign memr_n = ~sel[1];
  assign memw_n = ~sel[0];
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int unsigned HOST_AW   = 32,
  parameter int unsigned ISA_AW    = 24,
  parameter int unsigned DW        = 8,
  parameter int unsigned IO8_LEN   = 6,
  parameter int unsigned IO16_LEN  = 3,
  parameter int unsigned MEM8_LEN  = 6,
  parameter int unsigned MEM16_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic               req_write,
  input  logic               req_mem,
  input  logic               req_wide,
  input  logic               req_bios,
  output logic               done,
  output logic [DW-1:0]      rd_data,
  output logic [ISA_AW-1:0]  isa_addr,
  output logic [DW-1:0]      isa_data_out,
  output logic               isa_data_oe,
  input  logic [DW-1:0]      isa_data_in,
  output logic               ior_n,
  output logic               iow_n,
  output logic               memr_n,
  output logic               memw_n
);
  localparam int unsigned MAX_LEN = max4(IO8_LEN, IO16_LEN, MEM8_LEN, MEM16_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e             phase;
  logic [HOST_AW-1:0] q_addr;
  logic [DW-1:0]      q_wdata;
  logic               q_write, q_mem, q_wide, q_bios;

  // named internal events
  logic             take;
  logic             cmd_active;
  logic             cmd_last;
  logic             above_window;
  logic             mute_strobe;
  logic [CNT_W-1:0] cmd_len;

  assign take         = req_valid && (phase == PH_IDLE);
  assign cmd_active   = (phase == PH_CMD);
  assign above_window = |q_addr[HOST_AW-1:ISA_AW];
  assign mute_strobe  = q_mem && !q_bios && above_window;
  assign cmd_len      = CNT_W'(pick_len(q_mem, q_wide, IO8_LEN, IO16_LEN,
                                        MEM8_LEN, MEM16_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      q_addr  <= '0;
      q_wdata <= '0;
      q_write <= 1'b0;
      q_mem   <= 1'b0;
      q_wide  <= 1'b0;
      q_bios  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (take) begin
          phase   <= PH_SETUP;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          q_write <= req_write;
          q_mem   <= req_mem;
          q_wide  <= req_wide;
          q_bios  <= req_bios;
        end
        PH_SETUP: phase <= PH_CMD;
        PH_CMD:   if (cmd_last) phase <= PH_HOLD;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  isa_seq_timer #(.MAX_LEN(MAX_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (phase == PH_SETUP),
    .len       (cmd_len),
    .run       (cmd_active),
    .last_beat (cmd_last)
  );

  isa_seq_strobe u_strobe (
    .active (cmd_active),
    .write  (q_write),
    .mem    (q_mem),
    .mute   (mute_strobe),
    .ior_n  (ior_n),
    .iow_n  (iow_n),
    .memr_n (memr_n),
    .memw_n (memw_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (cmd_last && !q_write) begin
      rd_data <= isa_data_in;
    end
  end

  assign req_ready    = (phase == PH_IDLE);
  assign done         = (phase == PH_HOLD);
  assign isa_addr     = q_addr[ISA_AW-1:0];
  assign isa_data_out = q_wdata;
  assign isa_data_oe  = cmd_active && q_write;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 1) else $error("two strobes"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R11
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready || $stable(isa_addr))) else $error("address moved"); // R2
  AST_MUTED_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mute_strobe |-> (memr_n && memw_n)) else $error("muted strobe"); // R7
  AST_OE_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    isa_data_oe |-> (cmd_active && !req_ready)) else $error("stray oe"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ior_n && iow_n && memr_n && memw_n && !isa_data_oe && !done))
    else $error("idle not quiet"); // R1
endmodule

// File: tb/isa_cycle_seq_tb.sv
module isa_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0, req_mem = 1'b0, req_wide = 1'b0, req_bios = 1'b0;
  logic        done;
  logic [7:0]  rd_data;
  logic [23:0] isa_addr;
  logic [7:0]  isa_data_out;
  logic        isa_data_oe;
  logic [7:0]  isa_data_in = '0;
  logic        ior_n, iow_n, memr_n, memw_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_mem(req_mem), .req_wide(req_wide), .req_bios(req_bios),
    .done(done), .rd_data(rd_data), .isa_addr(isa_addr),
    .isa_data_out(isa_data_out), .isa_data_oe(isa_data_oe),
    .isa_data_in(isa_data_in), .ior_n(ior_n), .iow_n(iow_n),
    .memr_n(memr_n), .memw_n(memw_n)
  );

  function automatic int exp_len(input bit mem, input bit wide);
    if (!mem) return wide ? 3 : 6;
    return wide ? 3 : 6;
  endfunction

  // {io_rd, io_wr, mem_rd, mem_wr}
  function automatic logic [3:0] exp_mask(input bit wr, input bit mem,
                                         input bit bios, input logic [31:0] a);
    if (mem && !bios && a >= 32'h0100_0000) return 4'b0000;
    if (!mem) return wr ? 4'b0100 : 4'b1000;
    return wr ? 4'b0001 : 4'b0010;
  endfunction

  function automatic logic [3:0] act_mask();
    return ~{ior_n, iow_n, memr_n, memw_n};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [31:0] a, input logic [7:0] wd, input bit wr,
                         input bit mem, input bit wide, input bit bios, input bit poke);
    int          len;
    logic [3:0]  m;
    logic [7:0]  base;
    logic [7:0]  want_rd;
    len  = exp_len(mem, wide);
    m    = exp_mask(wr, mem, bios, a);
    base = 8'($urandom);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before", 32'(req_ready), 1);
    req_addr = a; req_wdata = wd; req_write = wr; req_mem = mem;
    req_wide = wide; req_bios = bios; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    isa_data_in = base ^ 8'd1;
    chk(req_ready == 1'b0, "R1 busy", 32'(req_ready), 0);
    chk(act_mask() == 4'b0000, "R2 setup no strobe", 32'(act_mask()), 0);
    chk(isa_addr == a[23:0], "R2 setup addr", 32'(isa_addr), 32'(a[23:0]));
    for (int k = 2; k <= len + 1; k++) begin
      @(negedge clk);
      isa_data_in = base ^ 8'(k);
      if (poke && k == 2) begin
        req_valid = 1'b1; req_addr = ~a; req_write = ~wr; req_mem = ~mem;
      end else begin
        req_valid = 1'b0;
      end
      chk(act_mask() == m,
          mem ? (m == 0 ? "R7 muted" : (bios ? "R8 bios strobe" : "R5 mem strobe"))
              : (wide ? "R4 io16 strobe" : "R3 io8 strobe"),
          32'(act_mask()), 32'(m));
      chk(isa_data_oe == wr, "R10 oe in cmd", 32'(isa_data_oe), 32'(wr));
      if (wr) chk(isa_data_out == wd, "R10 data out", 32'(isa_data_out), 32'(wd));
      chk(isa_addr == a[23:0], "R2 addr during strobe", 32'(isa_addr), 32'(a[23:0]));
    end
    want_rd = base ^ 8'(len + 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R11 done", 32'(done), 1);
    chk(act_mask() == 4'b0000, "R3 strobe ends on time", 32'(act_mask()), 0);
    chk(isa_data_oe == 1'b0, "R10 oe after", 32'(isa_data_oe), 0);
    chk(isa_addr == a[23:0], "R2 addr hold", 32'(isa_addr), 32'(a[23:0]));
    if (!wr) chk(rd_data == want_rd, "R9 read data", 32'(rd_data), 32'(want_rd));
    @(negedge clk);
    chk(done == 1'b0, "R11 done one clock", 32'(done), 0);
    chk(req_ready == 1'b1, "R11 ready again", 32'(req_ready), 1);
    chk(act_mask() == 4'b0000, "R1 poke ignored", 32'(act_mask()), 0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R12 reset ready/done",
        {30'd0, req_ready, done}, 32'd2);
    chk(act_mask() == 4'b0000 && !isa_data_oe, "R12 reset strobes",
        {27'd0, isa_data_oe, act_mask()}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && act_mask() == 0, "R12 after reset",
        {27'd0, req_ready, act_mask()}, 32'h10);
    // directed corners
    run_txn(32'h0000_03F8, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R3 io8 read
    run_txn(32'h0000_0060, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R3 io8 write, R1 poke
    run_txn(32'h0000_01F0, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); // R4 io16 read
    run_txn(32'h0000_0170, 8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R4 io16 write
    run_txn(32'h00FF_FFFF, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R5 just below window
    run_txn(32'h0100_0000, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R7 read muted
    run_txn(32'hFFFF_0000, 8'h99, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R7 write muted, R10
    run_txn(32'hFFFF_FFF0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R8 bios read
    run_txn(32'hFFF8_0000, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R8 bios write
    run_txn(32'h000C_8000, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R6 mem write
    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(0, 1) == 0) a[31:24] = 8'h00;
      run_txn(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule